// File: doc/BRIEF.md
# Operand Data Break Comparator

This block monitors accesses on an operand bus and flags a break condition when the data carried by an access equals a programmed 32-bit compare value. Bits can be left out of the comparison through a programmed mask. Software sets the compare value and the mask through a small register port. A separate enable input turns data matching on or off.

Each access supplies its size: byte, word, longword or quadword. The size decides which data bits take part in the comparison. For a quadword, both 32-bit halves of the 64-bit bus are checked against the same compare value and mask, and both must agree.

Cache-management operations carry no data value and are marked with a no-data flag. Such accesses never raise a data match. Neither does an access whose size is left unspecified. The result is a registered pulse, one cycle wide, that the surrounding break logic combines with its other conditions.

Top module: `data_break_match`

## Requirements
- R1: While reset is held and after it is released, `match_o` is low and both registers read back zero.
- R2: `reg_sel_i` = 0 selects the compare register and 1 selects the mask register. A write with `reg_we_i` high is visible on `reg_rdata_o` from the next cycle. An access presented in the same cycle as a write is judged against the old register values.
- R3: With size code 1 (byte), only data bits [7:0] are compared with compare bits [7:0].
- R4: With size code 2 (word), data bits [15:0] are compared with compare bits [15:0].
- R5: With size code 3 (longword), data bits [31:0] are compared with all 32 compare bits.
- R6: With size code 4 (quadword), data bits [31:0] and data bits [63:32] are each compared with the compare register under the mask. A match needs both halves to agree.
- R7: A mask bit of 1 removes that bit position from the comparison. A mask bit of 0 requires equality at that position.
- R8: An access with `acc_nodata_i` high never produces a match, whatever its data.
- R9: Size code 0 (unspecified) and codes 5 to 7 never produce a match.
- R10: With `match_en_i` low no match is produced. The value of `acc_write_i` has no effect on the result.
- R11: `match_o` is high in exactly the cycle after a valid access that matches, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = compare, 1 = mask |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read-back of the selected register |
| match_en_i | input | 1 | Enables data matching |
| acc_valid_i | input | 1 | An operand access is present |
| acc_size_i | input | 3 | Access size code |
| acc_write_i | input | 1 | Access direction, 1 = write |
| acc_nodata_i | input | 1 | The access carries no data value |
| acc_data_i | input | 64 | Operand data |
| match_o | output | 1 | Registered data-match pulse |

## Verification
The bench builds the block with its default values: a 32-bit compare width on a 64-bit bus, which gives two compare halves. With these values the quadword path, where one half matches and the other does not, is exercised directly. So is the size-dependent lane masking at the 8-, 16- and 32-bit boundaries. A random phase draws data that mostly differs from the compare value by a single bit flip. This brings single-bit differences in each lane and mask position within reach, including register writes made in the same cycle as an access.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [2:0] {
    SZ_NONE = 3'd0,
    SZ_BYTE = 3'd1,
    SZ_WORD = 3'd2,
    SZ_LONG = 3'd3,
    SZ_QUAD = 3'd4
  } acc_size_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned WORD_BITS = 16;
endpackage

// File: rtl/bdm_regs.sv
module bdm_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic [DATA_W-1:0] msk_o
);
  logic [DATA_W-1:0] cmp_q, msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      msk_q <= '0;
    end else if (we_i) begin
      if (sel_i) msk_q <= wdata_i;
      else       cmp_q <= wdata_i;
    end
  end

  assign cmp_o   = cmp_q;
  assign msk_o   = msk_q;
  assign rdata_o = sel_i ? msk_q : cmp_q;

  // R2: a write reaches the selected register one cycle later
  p_cmp_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !sel_i |=> cmp_o == $past(wdata_i));
  p_msk_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel_i |=> msk_o == $past(wdata_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cmp_o) && $stable(msk_o));
endmodule

// File: rtl/bdm_size_dec.sv
module bdm_size_dec
  import bdm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        size_i,
  output logic [DATA_W-1:0] lane_o,
  output logic              size_ok_o,
  output logic              quad_o
);
  localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] BYTE_LANE = ALL_ONES >> (DATA_W - BYTE_BITS);
  localparam logic [DATA_W-1:0] WORD_LANE = ALL_ONES >> (DATA_W - WORD_BITS);

  acc_size_e size;
  assign size = acc_size_e'(size_i);

  always_comb begin
    lane_o    = '0;
    size_ok_o = 1'b1;
    quad_o    = 1'b0;
    unique case (size)
      SZ_BYTE: lane_o = BYTE_LANE;
      SZ_WORD: lane_o = WORD_LANE;
      SZ_LONG: lane_o = ALL_ONES;
      SZ_QUAD: begin
        lane_o = ALL_ONES;
        quad_o = 1'b1;
      end
      default: size_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bdm_half_cmp.sv
module bdm_half_cmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic [DATA_W-1:0] msk_i,
  input  logic [DATA_W-1:0] lane_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] diff;
  // mask 1 = ignore bit; lane 0 = outside access size
  assign diff  = (data_i ^ cmp_i) & ~msk_i & lane_i;
  assign hit_o = (diff == '0);
endmodule

// File: rtl/data_break_match.sv
module data_break_match
  import bdm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BUS_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              match_en_i,
  input  logic              acc_valid_i,
  input  logic [2:0]        acc_size_i,
  input  logic              acc_write_i,
  input  logic              acc_nodata_i,
  input  logic [BUS_W-1:0]  acc_data_i,
  output logic              match_o
);
  localparam int unsigned NUM_HALVES = BUS_W / DATA_W;

  logic [DATA_W-1:0]     cmp, msk, lane;
  logic                  size_ok, quad;
  logic [NUM_HALVES-1:0] half_hit;
  logic                  data_hit, hit_d, match_q;

  bdm_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cmp_o   (cmp),
    .msk_o   (msk)
  );

  bdm_size_dec #(.DATA_W(DATA_W)) i_size_dec (
    .size_i    (acc_size_i),
    .lane_o    (lane),
    .size_ok_o (size_ok),
    .quad_o    (quad)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [DATA_W-1:0] half_lane;
    // upper halves are only consulted for quadword, where every lane counts
    if (h == 0) begin : g_low
      assign half_lane = lane;
    end else begin : g_high
      assign half_lane = '1;
    end
    bdm_half_cmp #(.DATA_W(DATA_W)) i_cmp (
      .data_i (acc_data_i[h*DATA_W +: DATA_W]),
      .cmp_i  (cmp),
      .msk_i  (msk),
      .lane_i (half_lane),
      .hit_o  (half_hit[h])
    );
  end

  assign data_hit = quad ? (&half_hit) : half_hit[0];
  assign hit_d    = acc_valid_i && match_en_i && !acc_nodata_i && size_ok && data_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= hit_d;
  end

  assign match_o = match_q;

  p_needs_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(acc_valid_i));
  p_nodata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> !$past(acc_nodata_i));
  p_size_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(acc_size_i) != 3'd0) && ($past(acc_size_i) <= 3'd4));
  p_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(match_en_i));
  p_dir_known_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> !$isunknown(acc_write_i));
endmodule

// File: tb/test_data_break_match.sv
`timescale 1ns/1ps
module test_data_break_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        match_en = 1'b0, acc_valid = 1'b0, acc_write = 1'b0, acc_nodata = 1'b0;
  logic [2:0]  acc_size = 3'd0;
  logic [63:0] acc_data = '0;
  logic        match;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_tag = "R11", exp_tag = "R11";
  bit exp_match = 1'b0;
  logic [31:0] m_cmp = '0, m_msk = '0;

  always #2.5 clk = ~clk;

  data_break_match i_data_break_match (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .match_en_i(match_en),
    .acc_valid_i(acc_valid), .acc_size_i(acc_size), .acc_write_i(acc_write),
    .acc_nodata_i(acc_nodata), .acc_data_i(acc_data), .match_o(match));

  function automatic bit ref_hit(int sz, bit v, bit en, bit nd, logic [63:0] d,
                                 logic [31:0] c, logic [31:0] m);
    int width;
    bit ok;
    if (!v || !en || nd) return 0;
    case (sz)
      1: width = 8;
      2: width = 16;
      3, 4: width = 32;
      default: return 0;
    endcase
    ok = 1;
    for (int i = 0; i < width; i++)
      if (!m[i] && d[i] != c[i]) ok = 0;
    if (sz == 4)
      for (int i = 0; i < 32; i++)
        if (!m[i] && d[32+i] != c[i]) ok = 0;
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = '0; m_msk = '0; exp_match = 0; exp_tag = "R1";
    end else begin
      exp_match = ref_hit(acc_size, acc_valid, match_en, acc_nodata, acc_data, m_cmp, m_msk);
      exp_tag = cur_tag;
      if (reg_we) begin
        if (reg_sel) m_msk = reg_wdata;
        else         m_cmp = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (match !== exp_match) begin
        fails++;
        $display("FAIL %s match_o: actual %b expected %b", exp_tag, match, exp_match);
      end
      checks++;
      if (reg_rdata !== (reg_sel ? m_msk : m_cmp)) begin
        fails++;
        $display("FAIL %s reg_rdata_o: actual %h expected %h", rst_n ? "R2" : "R1",
                 reg_rdata, reg_sel ? m_msk : m_cmp);
      end
    end
  end

  task automatic wr(bit sel, logic [31:0] v);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = v; acc_valid = 0; cur_tag = "R2";
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic acc(string tag, int sz, logic [63:0] d, bit nd = 0, bit w = 0, bit en = 1);
    @(negedge clk);
    cur_tag = tag; acc_valid = 1; acc_size = sz[2:0]; acc_data = d;
    acc_nodata = nd; acc_write = w; match_en = en;
    @(negedge clk);
    acc_valid = 0; cur_tag = "R11";
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);   // R1 reset state compared by monitor
    rst_n = 1;
    @(negedge clk);
    wr(0, 32'h1234_5678);
    wr(1, 32'h0000_0000);
    reg_sel = 0;
    acc("R3", 1, 64'h0000_0000_FFFF_FF78);
    acc("R3", 1, 64'h0000_0000_1234_5679);
    acc("R4", 2, 64'h0000_0000_AAAA_5678);
    acc("R4", 2, 64'h0000_0000_1234_5778);
    acc("R5", 3, 64'hDEAD_BEEF_1234_5678);
    acc("R5", 3, 64'h0000_0000_9234_5678);
    acc("R6", 4, 64'h1234_5678_1234_5678);
    acc("R6", 4, 64'h1234_5679_1234_5678);
    acc("R6", 4, 64'h1234_5678_0234_5678);
    acc("R8", 3, 64'h0000_0000_1234_5678, 1, 1);
    acc("R8", 3, 64'h0000_0000_1234_5678, 1, 0);
    acc("R9", 0, 64'h1234_5678_1234_5678);
    acc("R9", 5, 64'h1234_5678_1234_5678);
    acc("R9", 7, 64'h1234_5678_1234_5678);
    acc("R10", 3, 64'h0000_0000_1234_5678, 0, 0, 0);
    acc("R10", 3, 64'h0000_0000_1234_5678, 0, 1, 1);
    wr(1, 32'hF000_000F);
    reg_sel = 1;
    acc("R7", 3, 64'h0000_0000_A234_567F);
    acc("R7", 4, 64'h5234_5670_E234_5671);
    acc("R7", 3, 64'h0000_0000_1234_5658);
    // R2: write in the same cycle as an access
    @(negedge clk);
    reg_we = 1; reg_sel = 0; reg_wdata = 32'h0000_0000;
    acc_valid = 1; acc_size = 3'd3; acc_data = 64'h1234_5678; acc_nodata = 0; match_en = 1;
    cur_tag = "R2";
    @(negedge clk);
    reg_we = 0; acc_data = 64'h0; cur_tag = "R2";
    @(negedge clk);
    acc_valid = 0; cur_tag = "R11";
    // back-to-back matches, R11
    @(negedge clk);
    acc_valid = 1; acc_size = 3'd1; acc_data = '0; cur_tag = "R11";
    repeat (3) @(negedge clk);
    acc_valid = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_we = ($urandom_range(0, 15) == 0);
      reg_sel = $urandom_range(0, 1);
      reg_wdata = ($urandom_range(0, 3) == 0) ? $urandom : (reg_sel ? (32'h1 << $urandom_range(0, 31)) : m_cmp);
      acc_valid = $urandom_range(0, 3) != 0;
      acc_size = $urandom_range(0, 5);
      acc_nodata = ($urandom_range(0, 7) == 0);
      acc_write = $urandom_range(0, 1);
      match_en = ($urandom_range(0, 7) != 0);
      acc_data = {m_cmp, m_cmp};
      if ($urandom_range(0, 1)) acc_data[$urandom_range(0, 63)] ^= 1'b1;
      cur_tag = "R11";
    end
    @(negedge clk);
    reg_we = 0; acc_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule